// File: doc/BRIEF.md
# Peripheral DMA Channel Register Block

This block holds the host-visible register state of a single peripheral DMA channel. A host reads and writes four 32-bit words through a simple word-wide bus port: a control/status word, a memory address word, a byte count word, and an upper-address/test word. A word-index field in the bus offset selects the word. Reads return the selected word in the same cycle.

The control/status word joins bits the host may write with fields it may not write. The fixed fields are a version code, a pending-interrupt flag and an "address loaded" flag. The block watches the attached peripheral's interrupt line. On each edge of that line it updates the pending flag, and it gates the host interrupt with an interrupt-enable bit. It drives two controls toward the peripheral. The first is a one-cycle reset pulse. The second is a DMA-enable level that moves only when the host write changes the enable bit. The address word also works as a transfer pointer: on each transfer-complete strobe it advances by the reported byte length.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control/status word reads 0xA000_0000 and the address, count and upper words read 0. host_irq, periph_rst and dma_en are low.
- R2: Offset bits [3:2] select the word: 0 is control/status, 1 is address, 2 is count, 3 is upper. Offset bits [1:0] must be zero. bus_rdata shows the selected word in the same cycle, whether or not a request is made.
- R3: A control write takes bits 24..3 from the data and keeps the bits under mask 0xFE00_0007. Bits [31:28] always read 0xA. The pending flag at bit 0 cannot be written.
- R4: The drain-FIFO bit (bit 6) is never stored and always reads 0.
- R5: A control write with bit 7 set drives periph_rst high for exactly the next cycle. Bit 7 itself is stored like any other writable bit.
- R6: dma_en goes high after a control write that sets bit 9 while the stored bit 9 is clear. It goes low after a write that clears bit 9 while the stored bit is set. All other writes leave it unchanged.
- R7: A rising edge on periph_irq sets the pending flag (bit 0). If interrupt enable (bit 4) is set, it also raises host_irq.
- R8: A falling edge on periph_irq while pending is set clears pending. If interrupt enable is set, it also lowers host_irq.
- R9: A control write with bit 4 set raises host_irq when pending is set. A control write with bit 4 clear lowers host_irq when pending or the stored enable is set. A peripheral edge in the same cycle is applied first. host_irq is only ever high while both pending and enable are set.
- R10: Any write to the address word sets the loaded flag (bit 26 of the control/status word). Only reset clears it.
- R11: Each cycle with xfer_done high adds xfer_len to the address word, modulo 2^32. A host write to the address word in the same cycle takes priority.
- R12: The count and upper words read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | Write when high, read when low |
| bus_off | input | 4 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word |
| periph_irq | input | 1 | Interrupt level from the peripheral |
| xfer_done | input | 1 | Transfer-complete strobe |
| xfer_len | input | 16 | Bytes moved by the completed transfer |
| host_irq | output | 1 | Gated interrupt to the host |
| periph_rst | output | 1 | One-cycle peripheral reset pulse |
| dma_en | output | 1 | DMA-enable level |

## Verification
The hardest cases to reach are collisions within one cycle. In one, a peripheral interrupt edge arrives in the same cycle as a control write that changes interrupt enable. In the other, a transfer-complete strobe meets a host write to the address word. A bench that only runs tidy sequences never lines these up. So after a directed pass over each rule, the stimulus drives several thousand cycles of independent random bus traffic, interrupt toggles and strobes. A behavioural model that applies the peripheral event before the host write checks every cycle, so the collisions occur many times and each one is checked.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFF_W  = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    IDX_CTRL  = 2'd0,
    IDX_ADDR  = 2'd1,
    IDX_COUNT = 2'd2,
    IDX_UPPER = 2'd3
  } word_idx_e;

  localparam int unsigned BIT_PEND   = 0;
  localparam int unsigned BIT_IEN    = 4;
  localparam int unsigned BIT_DRAIN  = 6;
  localparam int unsigned BIT_PRST   = 7;
  localparam int unsigned BIT_WMEM   = 8;
  localparam int unsigned BIT_EN     = 9;
  localparam int unsigned BIT_LOADED = 26;

  localparam word_t RO_MASK   = 32'hFE00_0007;
  localparam word_t VERSION   = 32'hA000_0000;
  localparam word_t RESET_CSR = VERSION;

  // Host-owned bits of a control write: outside the fixed mask, drain dropped.
  function automatic word_t host_bits(word_t w);
    return w & ~RO_MASK & ~(word_t'(1) << BIT_DRAIN);
  endfunction

  // Assembled control/status view.
  function automatic word_t ctrl_view(word_t wr, logic pend, logic loaded);
    return VERSION | wr | (word_t'(loaded) << BIT_LOADED) | word_t'(pend);
  endfunction

  // Pointer advance, wrapping at the word width.
  function automatic word_t addr_step(word_t a, word_t len);
    return a + len;
  endfunction
endpackage

// File: rtl/dma_irq_gate.sv
module dma_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic periph_irq,
  input  logic ien,
  input  logic ctrl_wr,
  input  logic wr_ien,
  output logic pending,
  output logic host_irq
);
  logic irq_prev;
  logic irq_rise;
  logic irq_fall;
  logic pend_mid, hirq_mid, pend_nx, hirq_nx;

  assign irq_rise = periph_irq & ~irq_prev;
  assign irq_fall = ~periph_irq & irq_prev;

  always_comb begin
    pend_mid = pending;
    hirq_mid = host_irq;
    if (irq_rise) begin
      pend_mid = 1'b1;
      if (ien) hirq_mid = 1'b1;
    end else if (irq_fall && pending) begin
      pend_mid = 1'b0;
      if (ien) hirq_mid = 1'b0;
    end
    pend_nx = pend_mid;
    hirq_nx = hirq_mid;
    if (ctrl_wr) begin
      if (wr_ien) begin
        if (pend_mid) hirq_nx = 1'b1;
      end else if (pend_mid || ien) begin
        hirq_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev <= 1'b0;
      pending  <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      irq_prev <= periph_irq;
      pending  <= pend_nx;
      host_irq <= hirq_nx;
    end
  end

  assert_rise_sets_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> pending);
  assert_fall_clears_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fall && pending) |=> !pending);
  assert_host_needs_pend_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (pending && ien));
endmodule

// File: rtl/dma_ctrl_csr.sv
module dma_ctrl_csr
  import dma_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_wr,
  input  logic  addr_wr,
  input  word_t wdata,
  input  logic  pending,
  output word_t ctrl_word,
  output logic  ien,
  output logic  periph_rst,
  output logic  dma_en
);
  word_t wr_bits;
  logic  loaded;

  assign ien       = wr_bits[BIT_IEN];
  assign ctrl_word = ctrl_view(wr_bits, pending, loaded);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bits    <= '0;
      loaded     <= 1'b0;
      periph_rst <= 1'b0;
      dma_en     <= 1'b0;
    end else begin
      periph_rst <= ctrl_wr & wdata[BIT_PRST];
      if (ctrl_wr) begin
        wr_bits <= host_bits(wdata);
        if (wdata[BIT_EN] && !wr_bits[BIT_EN])
          dma_en <= 1'b1;
        else if (!wdata[BIT_EN] && wr_bits[BIT_EN])
          dma_en <= 1'b0;
      end
      if (addr_wr) loaded <= 1'b1;
    end
  end

  assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[BIT_PRST]) |=> periph_rst);
  assert_rst_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> $past(ctrl_wr));
  assert_en_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[BIT_EN]) |=> dma_en);
  assert_en_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(dma_en));
  assert_fixed_bits_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_word[31:25] == $past(ctrl_word[31:25])));
  assert_loaded_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> ctrl_word[BIT_LOADED]);
endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt
  import dma_regs_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_wr,
  input  word_t            wdata,
  input  logic             xfer_done,
  input  logic [LEN_W-1:0] xfer_len,
  output word_t            addr_q
);
  word_t len_ext;
  assign len_ext = word_t'(xfer_len);

  always_ff @(posedge clk) begin
    if (!rst_n)         addr_q <= '0;
    else if (addr_wr)   addr_q <= wdata;
    else if (xfer_done) addr_q <= addr_step(addr_q, len_ext);
  end

  assert_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !addr_wr) |=> (addr_q == $past(addr_q) + $past(len_ext)));
  assert_host_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (addr_q == $past(wdata)));
endmodule

// File: rtl/dma_word_reg.sv
module dma_word_reg
  import dma_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  word_t wdata,
  output word_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end

  assert_readback_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == $past(wdata)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [3:0]       bus_off,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             periph_irq,
  input  logic             xfer_done,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             host_irq,
  output logic             periph_rst,
  output logic             dma_en
);
  localparam int unsigned NWORDS = 4;

  word_idx_e   sel_idx;
  logic        any_wr;
  logic [NWORDS-1:0] word_wr;
  word_t       words [NWORDS];
  logic        pending, ien;

  assign sel_idx = word_idx_e'(bus_off[3:2]);
  assign any_wr  = bus_sel & bus_we;

  for (genvar i = 0; i < NWORDS; i++) begin : g_dec
    assign word_wr[i] = any_wr && (sel_idx == word_idx_e'(i));
  end

  dma_irq_gate u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_irq (periph_irq),
    .ien        (ien),
    .ctrl_wr    (word_wr[IDX_CTRL]),
    .wr_ien     (bus_wdata[BIT_IEN]),
    .pending    (pending),
    .host_irq   (host_irq)
  );

  dma_ctrl_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (word_wr[IDX_CTRL]),
    .addr_wr    (word_wr[IDX_ADDR]),
    .wdata      (bus_wdata),
    .pending    (pending),
    .ctrl_word  (words[IDX_CTRL]),
    .ien        (ien),
    .periph_rst (periph_rst),
    .dma_en     (dma_en)
  );

  dma_addr_cnt #(.LEN_W(LEN_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_wr   (word_wr[IDX_ADDR]),
    .wdata     (bus_wdata),
    .xfer_done (xfer_done),
    .xfer_len  (xfer_len),
    .addr_q    (words[IDX_ADDR])
  );

  for (genvar j = 2; j < NWORDS; j++) begin : g_plain
    dma_word_reg u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (word_wr[j]),
      .wdata (bus_wdata),
      .q     (words[j])
    );
  end

  assign bus_rdata = words[sel_idx];

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> (bus_off[1:0] == 2'b00));
  assert_en_matches_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en == words[IDX_CTRL][BIT_EN]);
  assert_drain_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr[IDX_CTRL] |=> !words[IDX_CTRL][BIT_DRAIN]);
endmodule

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/100ps
module dma_chan_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [3:0]  bus_off;
  logic [31:0] bus_wdata, bus_rdata;
  logic        periph_irq, xfer_done;
  logic [15:0] xfer_len;
  logic        host_irq, periph_rst, dma_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_irq(periph_irq), .xfer_done(xfer_done), .xfer_len(xfer_len),
    .host_irq(host_irq), .periph_rst(periph_rst), .dma_en(dma_en)
  );

  // Behavioural reference state
  bit [31:0] m_host, m_addr, m_cnt, m_up;
  bit m_pend, m_loaded, m_hirq, m_rst, m_en, m_prev;

  function automatic bit [31:0] m_word(int idx);
    case (idx)
      0: return 32'hA000_0000 | (m_loaded ? 32'h0400_0000 : 0) | m_host | (m_pend ? 1 : 0);
      1: return m_addr;
      2: return m_cnt;
      default: return m_up;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_host = 0; m_addr = 0; m_cnt = 0; m_up = 0;
    m_pend = 0; m_loaded = 0; m_hirq = 0; m_rst = 0; m_en = 0; m_prev = 0;
  endtask

  task automatic model_step(bit s, bit w, int idx, bit [31:0] d, bit irq, bit dn, bit [15:0] ln);
    bit wr = s && w;
    bit ien = m_host[4];
    bit np = m_pend, nh = m_hirq;
    if (irq && !m_prev) begin np = 1; if (ien) nh = 1; end
    else if (!irq && m_prev && m_pend) begin np = 0; if (ien) nh = 0; end
    if (wr && idx == 0) begin
      if (d[4]) begin if (np) nh = 1; end
      else if (np || ien) nh = 0;
    end
    m_rst = wr && idx == 0 && d[7];
    if (wr && idx == 0) begin
      if (d[9] && !m_host[9]) m_en = 1;
      else if (!d[9] && m_host[9]) m_en = 0;
      m_host = d & 32'h01FF_FFB8;
    end
    if (wr && idx == 1) begin m_loaded = 1; m_addr = d; end
    else if (dn) m_addr = m_addr + {16'h0, ln};
    if (wr && idx == 2) m_cnt = d;
    if (wr && idx == 3) m_up = d;
    m_pend = np; m_hirq = nh; m_prev = irq;
  endtask

  // One cycle: drive at negedge, check read path, step model, check registered outputs.
  task automatic cyc(bit s, bit w, int idx, bit [31:0] d, bit irq, bit dn, bit [15:0] ln);
    string rtag;
    bus_sel = s; bus_we = w; bus_off = {idx[1:0], 2'b00}; bus_wdata = d;
    periph_irq = irq; xfer_done = dn; xfer_len = ln;
    #1;
    rtag = (idx == 0) ? "R3 ctrl" : (idx == 1) ? "R11 addr" : "R12 word";
    chk(bus_rdata == m_word(idx), rtag, bus_rdata, m_word(idx));
    model_step(s, w, idx, d, irq, dn, ln);
    @(negedge clk);
    chk(host_irq == m_hirq, "R9 host_irq", {31'b0, host_irq}, {31'b0, m_hirq});
    chk(periph_rst == m_rst, "R5 periph_rst", {31'b0, periph_rst}, {31'b0, m_rst});
    chk(dma_en == m_en, "R6 dma_en", {31'b0, dma_en}, {31'b0, m_en});
  endtask

  task automatic peek(int idx, bit [31:0] exp, string tag);
    bus_sel = 0; bus_off = {idx[1:0], 2'b00};
    #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit cur_irq = 0;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_off = 0; bus_wdata = 0;
    periph_irq = 0; xfer_done = 0; xfer_len = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values
    peek(0, 32'hA000_0000, "R1 ctrl reset");
    peek(1, 0, "R1 addr reset");
    peek(2, 0, "R1 count reset");
    peek(3, 0, "R1 upper reset");
    chk(!host_irq && !periph_rst && !dma_en, "R1 outputs low", {29'b0, host_irq, periph_rst, dma_en}, 0);
    // R2 / R12: offset 0x8 selects count, read visible same cycle
    cyc(1, 1, 2, 32'h1234_5678, 0, 0, 0);
    peek(2, 32'h1234_5678, "R2 index from offset bits 3:2");
    cyc(1, 1, 3, 32'hCAFE_0001, 0, 0, 0);
    peek(3, 32'hCAFE_0001, "R12 upper readback");
    // R3 R4 R5 R6: all-ones control write
    cyc(1, 1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    chk(periph_rst == 1, "R5 pulse after write", {31'b0, periph_rst}, 1);
    chk(dma_en == 1, "R6 enable rises", {31'b0, dma_en}, 1);
    peek(0, 32'hA1FF_FFB8, "R3 merge, R4 drain reads 0");
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk(periph_rst == 0, "R5 pulse one cycle", {31'b0, periph_rst}, 0);
    chk(host_irq == 0, "R9 enable without pending", {31'b0, host_irq}, 0);
    // R7: rising peripheral interrupt with enable set
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk(host_irq == 1, "R7 host raised", {31'b0, host_irq}, 1);
    peek(0, 32'hA1FF_FFB9, "R7 pending bit 0");
    // R9: clear enable, then set it again while pending
    cyc(1, 1, 0, 32'h0000_0200, 1, 0, 0);
    chk(host_irq == 0, "R9 disable drops", {31'b0, host_irq}, 0);
    chk(dma_en == 1, "R6 unchanged when bit kept", {31'b0, dma_en}, 1);
    cyc(1, 1, 0, 32'h0000_0210, 1, 0, 0);
    chk(host_irq == 1, "R9 enable with pending raises", {31'b0, host_irq}, 1);
    // R8: falling edge
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk(host_irq == 0, "R8 host dropped", {31'b0, host_irq}, 0);
    peek(0, 32'hA000_0210, "R8 pending cleared");
    // R10 R11
    cyc(1, 1, 1, 32'h0000_1000, 0, 0, 0);
    peek(0, 32'hA400_0210, "R10 loaded bit 26");
    cyc(0, 0, 1, 0, 0, 1, 16'h0020);
    peek(1, 32'h0000_1020, "R11 advance by length");
    cyc(1, 1, 1, 32'h0000_5000, 0, 1, 16'h0040);
    peek(1, 32'h0000_5000, "R11 host write wins");
    cyc(1, 1, 1, 32'hFFFF_FFF0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 1, 16'h0020);
    peek(1, 32'h0000_0010, "R11 wraps");
    // R6: clearing the enable bit
    cyc(1, 1, 0, 32'h0, 0, 0, 0);
    chk(dma_en == 0, "R6 enable falls", {31'b0, dma_en}, 0);
    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      bit s = ($urandom % 2) == 0;
      if (($urandom % 6) == 0) cur_irq = ~cur_irq;
      cyc(s, $urandom % 3 != 0, int'($urandom % 4), $urandom, cur_irq,
          ($urandom % 4) == 0, 16'($urandom));
    end
    finish_run();
  end
endmodule